// File: doc/BRIEF.md
# Per-Cycle Shared Bus Arbiter with External Bus-Clear

This block decides who owns an internal shared bus, one bus cycle at a time. Each bus cycle runs through three sub-states, S0, S2 and S4. At the boundary at the end of S4, the arbiter samples the request lines and hands the next cycle to one owner. An external request outranks every internal master. Among the internal masters, the one with the largest fixed arbitration ID wins.

One internal master is a DMA-style requester. It may compete only while the current interrupt service level is at or below the programmed mask. When it wins, it owns two bus cycles back to back: a read cycle, then a write cycle.

While the DMA requester wants the bus or is moving data, the block can raise a bus-clear output. This output tells an external master to get off the external bus. It is raised only if the requester's ID is strictly above a 3-bit programmed threshold and the pin is enabled. It falls during S2 of the write cycle, so it is already low before the bus is released.

Top module: `cyc_bus_arbiter`

## Requirements
- R1: After a clock edge with `rst_n` low, these outputs are all zero:
  - `grant_o`
  - `bus_clr_o`
  - `phase_o` (which means S0)
  - `xfer_o` (which means no DMA transfer)
- R2: `phase_o` steps S0 (0) → S2 (1) → S4 (2) → S0, one clock each. Requests are sampled only at the clock edge that ends S4. `grant_o` changes only at that edge and stays constant for the whole cycle, however the requests move inside it.
- R3: Among the eligible internal requesters, the one with the largest arbitration ID gets the next cycle. On equal IDs the lower index wins. With the default IDs (2, 5, 5, 6 for masters 0 to 3), master 1 beats master 2.
- R4: When `ext_req_i` is high at a boundary, `grant_o[NUM_MASTERS]` is granted and no internal master is granted. The one exception is the boundary that ends a DMA read cycle (see R7).
- R5: The DMA requester (master `DMA_IDX`, default 3) is eligible only when `irq_level_i <= irq_mask_i`. Otherwise its request is ignored at that boundary.
- R6: `grant_o` is one-hot, or all zero when nobody requested at the last boundary.
- R7: When the DMA requester wins, `xfer_o` shows read (1) for that cycle. The next cycle is always granted to the DMA requester with `xfer_o` = write (2), whatever the other requests are. In every other cycle `xfer_o` is 0.
- R8: `bus_clr_o` is high in a clock only if the DMA requester's ID is strictly greater than `clr_thr_i` as sampled at the previous edge. When that holds and the pin is enabled, `bus_clr_o` follows one clock after an eligible DMA request. It stays high through the read cycle and through S0 of the write cycle.
- R9: If `clr_pin_en_i` is low at an edge, `bus_clr_o` is low in the following clock.
- R10: `bus_clr_o` is low during S2 and S4 of a DMA write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | NUM_MASTERS | Request line per internal master |
| ext_req_i | input | 1 | External master requesting the bus |
| irq_level_i | input | LVL_W | Interrupt service level currently pending |
| irq_mask_i | input | LVL_W | Programmed interrupt service mask |
| clr_thr_i | input | ID_W | Bus-clear ID threshold |
| clr_pin_en_i | input | 1 | Enables the bus-clear pin |
| grant_o | output | NUM_MASTERS+1 | One-hot grant; top bit is the external master |
| bus_clr_o | output | 1 | Bus-clear request to the external master |
| phase_o | output | 2 | Sub-state: 0=S0, 1=S2, 2=S4 |
| xfer_o | output | 2 | DMA transfer state: 0 none, 1 read, 2 write |

## Verification
The bench goes after four corner cases:
- **Tie between masters 1 and 2.** A reversed tie rule hands the cycle to master 2.
- **Threshold equal to the DMA ID.** A non-strict compare raises the clear output there.
- **Interrupt level equal to the mask.** An off-by-one gate locks the DMA requester out exactly at that point.
- **External request at the boundary that ends a DMA read.** An arbiter without the transfer lock gives the write cycle away.

Inputs are also changed every clock with a pseudo-random sequence, so requests that appear or vanish inside a cycle are exposed. A design that samples them anywhere but the S4 edge shows a grant change mid-cycle. Finally, the bench watches the clear output through the whole write cycle. A design that drops it late, or not at all, is caught in S2.

// File: rtl/arb_pkg.sv
// Shared types for the per-cycle bus arbiter.
// Assumes: sub-state and transfer codes are visible at the ports, so the
// encodings below are fixed.
package arb_pkg;

    typedef enum logic [1:0] {
        PH_S0 = 2'd0,
        PH_S2 = 2'd1,
        PH_S4 = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        XF_NONE  = 2'd0,
        XF_READ  = 2'd1,
        XF_WRITE = 2'd2
    } xfer_e;

endpackage

// File: rtl/arb_phase_seq.sv
// Bus-cycle sub-state sequencer: S0 -> S2 -> S4 -> S0, one clock each.
// Assumes: every bus cycle takes three clocks; the boundary flag marks the
// last clock of a cycle, where the arbiter makes its decision.
module arb_phase_seq
    import arb_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output phase_e phase_o,
    output logic   boundary_o
);

    phase_e phase_q;

    // Advance the sub-state each clock; reset lands in S0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_S0;
        end else begin
            unique case (phase_q)
                PH_S0:   phase_q <= PH_S2;
                PH_S2:   phase_q <= PH_S4;
                default: phase_q <= PH_S0;
            endcase
        end
    end

    // The edge that ends S4 is the only arbitration point.
    always_comb boundary_o = (phase_q == PH_S4);

    assign phase_o = phase_q;

endmodule

// File: rtl/arb_winner.sv
// Combinational winner select over the eligible internal requests.
// Assumes: each master has a fixed ID; the larger ID wins, and on equal IDs
// the lower index wins (strict compare while scanning upward).
module arb_winner #(
    parameter int                            NUM_MASTERS = 4,
    parameter int                            ID_W        = 3,
    parameter logic [NUM_MASTERS*ID_W-1:0]   MASTER_IDS  = 12'hD6A
) (
    input  logic [NUM_MASTERS-1:0] req_i,
    output logic [NUM_MASTERS-1:0] win_o,
    output logic                   any_o
);

    // Scan masters in index order, keeping the best ID seen so far.
    always_comb begin
        logic [ID_W-1:0] best_id;
        logic            found;
        best_id = '0;
        found   = 1'b0;
        win_o   = '0;
        for (int i = 0; i < NUM_MASTERS; i++) begin
            if (req_i[i] && (!found || (MASTER_IDS[i*ID_W +: ID_W] > best_id))) begin
                found    = 1'b1;
                best_id  = MASTER_IDS[i*ID_W +: ID_W];
                win_o    = '0;
                win_o[i] = 1'b1;
            end
        end
        any_o = found;
    end

endmodule

// File: rtl/arb_busclr.sv
// Bus-clear output register.
// Assumes: the clear goes out only when the DMA ID is strictly above the
// threshold and the pin is enabled. It is held through the read cycle and
// S0 of the write cycle, and is low from S2 of the write cycle onward.
module arb_busclr
    import arb_pkg::*;
#(
    parameter int              ID_W   = 3,
    parameter logic [ID_W-1:0] DMA_ID = 3'd6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pin_en_i,
    input  logic [ID_W-1:0] thr_i,
    input  logic            dma_want_i,
    input  xfer_e           xfer_i,
    input  phase_e          phase_i,
    output logic            bus_clr_o
);

    logic above_thr;
    logic wr_closing;
    logic clr_next;
    logic clr_q;

    // Decide what the clear output shows in the next clock.
    always_comb begin
        above_thr  = (DMA_ID > thr_i);
        wr_closing = (xfer_i == XF_WRITE) && (phase_i != PH_S4);
        clr_next   = pin_en_i && above_thr &&
                     ((xfer_i == XF_READ) || (!wr_closing && dma_want_i));
    end

    // Register the clear output; reset deasserts it.
    always_ff @(posedge clk) begin
        if (!rst_n) clr_q <= 1'b0;
        else        clr_q <= clr_next;
    end

    assign bus_clr_o = clr_q;

endmodule

// File: rtl/cyc_bus_arbiter.sv
// Per-cycle shared bus arbiter with DMA interrupt gate and external bus-clear.
// Assumes: arbitration happens once per three-clock bus cycle, at the edge
// ending S4. The external request outranks internal masters except on the
// locked write half of a DMA transfer. grant_o[NUM_MASTERS] is the external
// master.
module cyc_bus_arbiter
    import arb_pkg::*;
#(
    parameter int                          NUM_MASTERS = 4,
    parameter int                          ID_W        = 3,
    parameter int                          LVL_W       = 3,
    parameter logic [NUM_MASTERS*ID_W-1:0] MASTER_IDS  = 12'hD6A,
    parameter int                          DMA_IDX     = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_MASTERS-1:0] req_i,
    input  logic                   ext_req_i,
    input  logic [LVL_W-1:0]       irq_level_i,
    input  logic [LVL_W-1:0]       irq_mask_i,
    input  logic [ID_W-1:0]        clr_thr_i,
    input  logic                   clr_pin_en_i,
    output logic [NUM_MASTERS:0]   grant_o,
    output logic                   bus_clr_o,
    output logic [1:0]             phase_o,
    output logic [1:0]             xfer_o
);

    localparam logic [ID_W-1:0]      DMA_ID  = MASTER_IDS[DMA_IDX*ID_W +: ID_W];
    localparam logic [NUM_MASTERS:0] DMA_GNT = {{NUM_MASTERS{1'b0}}, 1'b1} << DMA_IDX;
    localparam logic [NUM_MASTERS:0] EXT_GNT = {1'b1, {NUM_MASTERS{1'b0}}};

    phase_e                   phase;
    logic                     boundary;
    logic                     dma_gate;
    logic [NUM_MASTERS-1:0]   req_elig;
    logic [NUM_MASTERS-1:0]   win;
    logic                     win_any;
    logic [NUM_MASTERS:0]     grant_q;
    xfer_e                    xfer_q;

    arb_phase_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_o    (phase),
        .boundary_o (boundary)
    );

    // DMA may compete only while the pending level is within the mask.
    always_comb dma_gate = (irq_level_i <= irq_mask_i);

    // Per-master eligibility; only the DMA slot carries the interrupt gate.
    for (genvar g = 0; g < NUM_MASTERS; g++) begin : g_elig
        if (g == DMA_IDX) begin : g_dma
            assign req_elig[g] = req_i[g] && dma_gate;
        end else begin : g_plain
            assign req_elig[g] = req_i[g];
        end
    end

    arb_winner #(
        .NUM_MASTERS (NUM_MASTERS),
        .ID_W        (ID_W),
        .MASTER_IDS  (MASTER_IDS)
    ) u_win (
        .req_i (req_elig),
        .win_o (win),
        .any_o (win_any)
    );

    // Commit the owner and DMA transfer state at each cycle boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q <= '0;
            xfer_q  <= XF_NONE;
        end else if (boundary) begin
            if (xfer_q == XF_READ) begin
                grant_q <= DMA_GNT;
                xfer_q  <= XF_WRITE;
            end else if (ext_req_i) begin
                grant_q <= EXT_GNT;
                xfer_q  <= XF_NONE;
            end else if (win_any) begin
                grant_q <= {1'b0, win};
                xfer_q  <= win[DMA_IDX] ? XF_READ : XF_NONE;
            end else begin
                grant_q <= '0;
                xfer_q  <= XF_NONE;
            end
        end
    end

    arb_busclr #(
        .ID_W   (ID_W),
        .DMA_ID (DMA_ID)
    ) u_clr (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_en_i   (clr_pin_en_i),
        .thr_i      (clr_thr_i),
        .dma_want_i (req_elig[DMA_IDX]),
        .xfer_i     (xfer_q),
        .phase_i    (phase),
        .bus_clr_o  (bus_clr_o)
    );

    assign grant_o = grant_q;
    assign phase_o = phase;
    assign xfer_o  = xfer_q;

endmodule

// File: rtl/cyc_bus_arbiter_checks.sv
// Property checker for cyc_bus_arbiter, attached by bind.
// Assumes: port encodings as in arb_pkg; only top-level ports are observed.
module cyc_bus_arbiter_checks #(
    parameter int                          NUM_MASTERS = 4,
    parameter int                          ID_W        = 3,
    parameter int                          LVL_W       = 3,
    parameter logic [NUM_MASTERS*ID_W-1:0] MASTER_IDS  = 12'hD6A,
    parameter int                          DMA_IDX     = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   ext_req_i,
    input logic [LVL_W-1:0]       irq_level_i,
    input logic [LVL_W-1:0]       irq_mask_i,
    input logic [ID_W-1:0]        clr_thr_i,
    input logic                   clr_pin_en_i,
    input logic [NUM_MASTERS:0]   grant_o,
    input logic                   bus_clr_o,
    input logic [1:0]             phase_o,
    input logic [1:0]             xfer_o
);

    localparam logic [ID_W-1:0] DMA_ID = MASTER_IDS[DMA_IDX*ID_W +: ID_W];

    p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    p_phase_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd2) |=> (phase_o == 2'd0));

    p_grant_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o != 2'd0) |-> $stable(grant_o));

    p_ext_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd2 && ext_req_i && xfer_o != 2'd1) |=> grant_o[NUM_MASTERS]);

    p_dma_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd2 && irq_level_i > irq_mask_i && xfer_o != 2'd1)
            |=> !grant_o[DMA_IDX]);

    p_write_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd2 && xfer_o == 2'd1)
            |=> (xfer_o == 2'd2 && grant_o[DMA_IDX]));

    p_thr_strict_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (DMA_ID <= clr_thr_i) |=> !bus_clr_o);

    p_pin_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_pin_en_i |=> !bus_clr_o);

    p_clr_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_o == 2'd2 && phase_o != 2'd0) |-> !bus_clr_o);

endmodule

bind cyc_bus_arbiter cyc_bus_arbiter_checks #(
    .NUM_MASTERS (NUM_MASTERS),
    .ID_W        (ID_W),
    .LVL_W       (LVL_W),
    .MASTER_IDS  (MASTER_IDS),
    .DMA_IDX     (DMA_IDX)
) u_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .ext_req_i    (ext_req_i),
    .irq_level_i  (irq_level_i),
    .irq_mask_i   (irq_mask_i),
    .clr_thr_i    (clr_thr_i),
    .clr_pin_en_i (clr_pin_en_i),
    .grant_o      (grant_o),
    .bus_clr_o    (bus_clr_o),
    .phase_o      (phase_o),
    .xfer_o       (xfer_o)
);

// File: tb/cyc_bus_arbiter_bench.sv
// Self-checking bench: a per-clock reference model built from the
// requirements, driven by structured sweeps and a pseudo-random phase.
module cyc_bus_arbiter_bench;

    localparam int               N     = 4;
    localparam int               IW    = 3;
    localparam int               LW    = 3;
    localparam logic [N*IW-1:0]  IDS   = 12'hD6A;   // ids 2,5,5,6
    localparam int               DMA   = 3;
    localparam int               DMAID = 6;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [N-1:0]  req;
    logic          ext;
    logic [LW-1:0] lvl, msk;
    logic [IW-1:0] thr;
    logic          pin;
    logic [N:0]    grant;
    logic          bclr;
    logic [1:0]    phase, xfer;

    int nvec  = 0;
    int nfail = 0;
    string g_tag = "R3";

    // Reference model state.
    int         m_ph;
    int         m_x;
    logic [N:0] m_g;
    logic       m_b;

    always #4 clk = ~clk;

    cyc_bus_arbiter #(
        .NUM_MASTERS (N),
        .ID_W        (IW),
        .LVL_W       (LW),
        .MASTER_IDS  (IDS),
        .DMA_IDX     (DMA)
    ) u_cyc_bus_arbiter (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req),
        .ext_req_i    (ext),
        .irq_level_i  (lvl),
        .irq_mask_i   (msk),
        .clr_thr_i    (thr),
        .clr_pin_en_i (pin),
        .grant_o      (grant),
        .bus_clr_o    (bclr),
        .phase_o      (phase),
        .xfer_o       (xfer)
    );

    // Model update at each edge, derived from R1..R10.
    always @(posedge clk) begin
        int         nph, nx, best, wi;
        logic [N:0] ng;
        logic       nb, dma_ok;
        if (!rst_n) begin
            m_ph = 0; m_x = 0; m_g = '0; m_b = 1'b0;
        end else begin
            dma_ok = req[DMA] && (lvl <= msk);
            nph = (m_ph == 2) ? 0 : m_ph + 1;
            nx  = m_x;
            ng  = m_g;
            if (m_ph == 2) begin
                if (m_x == 1) begin
                    ng = '0; ng[DMA] = 1'b1; nx = 2;
                end else if (ext) begin
                    ng = '0; ng[N] = 1'b1; nx = 0;
                end else begin
                    best = -1; wi = -1;
                    for (int i = 0; i < N; i++) begin
                        if ((i == DMA ? dma_ok : req[i]) && int'(IDS[i*IW +: IW]) > best) begin
                            best = int'(IDS[i*IW +: IW]); wi = i;
                        end
                    end
                    ng = '0;
                    if (wi >= 0) ng[wi] = 1'b1;
                    nx = (wi == DMA) ? 1 : 0;
                end
            end
            nb = pin && (DMAID > int'(thr)) &&
                 (m_x == 1 || (!(m_x == 2 && m_ph != 2) && dma_ok));
            m_ph = nph; m_x = nx; m_g = ng; m_b = nb;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Wait one clock, then compare every output against the model.
    task automatic step();
        string b_tag;
        @(negedge clk);
        b_tag = (m_x == 2 && m_ph != 0) ? "R10" : (pin ? "R8" : "R9");
        chk("R2", int'(phase), m_ph);
        chk("R7", int'(xfer), m_x);
        chk(g_tag, int'(grant), int'(m_g));
        chk("R6", ($countones(grant) <= 1) ? 1 : 0, 1);
        chk(b_tag, int'(bclr), int'(m_b));
    endtask

    initial begin : watchdog
        #(8 * 200000);
        nfail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin : main
        logic [31:0] lf;
        rst_n = 1'b0; req = '0; ext = 1'b0; lvl = '0; msk = '0; thr = '0; pin = 1'b1;
        req = 4'hF; ext = 1'b1;
        repeat (2) @(negedge clk);
        // R1: reset state despite active inputs
        chk("R1", int'(grant), 0);
        chk("R1", int'(bclr), 0);
        chk("R1", int'(phase), 0);
        chk("R1", int'(xfer), 0);
        req = '0; ext = 1'b0;
        rst_n = 1'b1;

        // Sweep A: every request pattern, ext, gate open/closed, pin on/off.
        for (int p = 0; p < 16; p++) begin
            for (int e = 0; e < 2; e++) begin
                for (int gt = 0; gt < 2; gt++) begin
                    for (int pe = 0; pe < 2; pe++) begin
                        req = 4'(p); ext = e[0]; pin = pe[0]; thr = '0;
                        lvl = gt[0] ? 3'd5 : 3'd4;   // level == mask when open
                        msk = 3'd4;
                        g_tag = e[0] ? "R4" : (gt[0] ? "R5" : "R3");
                        repeat (9) step();
                    end
                end
            end
        end

        // Sweep B: threshold, level and mask, DMA alone plus external contention.
        for (int t = 0; t < 8; t++) begin
            for (int l = 0; l < 8; l++) begin
                for (int m = 0; m < 8; m++) begin
                    req = 4'b1000; thr = 3'(t); lvl = 3'(l); msk = 3'(m);
                    pin = 1'b1; ext = (t[0] && m[1]);
                    g_tag = (l > m) ? "R5" : "R7";
                    repeat (6) step();
                end
            end
        end

        // Sweep C: inputs change every clock, including mid-cycle.
        lf = 32'hACE1_2357;
        g_tag = "R2";
        for (int k = 0; k < 6000; k++) begin
            lf  = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            req = lf[3:0];
            ext = (lf[6:4] == 3'd0);
            lvl = lf[9:7];
            msk = lf[12:10];
            thr = lf[15:13];
            pin = (lf[18:16] != 3'd0);
            step();
        end

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule